// File: doc/BRIEF.md
# Scatter-Gather List Walker with Word-Burst Copy

This block moves data from a card-side address range to a host-side address range. The moves are described by a linked chain of descriptors in memory. Software writes the address of the first descriptor into a base register and then writes a start command. From then on the engine works without software help. For each descriptor it fetches three words: the source address, the destination address, and a control word. The control word carries the byte count and an end-of-chain flag. The engine copies the data one 32-bit word at a time and then steps to the next descriptor.

When the engine finishes a descriptor that carries the end-of-chain flag, it records completion in a status register and raises its interrupt line. Three faults stop the chain early and are reported as separate sticky status bits: a badly formed byte count, a failed memory read, and a failed memory write. Software clears status bits by writing ones to them. The engine reaches memory through a single request/acknowledge port that has one access outstanding at a time.

Top module: `sg_dma_engine`

## Requirements
- R1: A descriptor is three words at byte offsets +0, +4 and +8. The first word is the source address and the second is the destination address. In the control word, bits 17:0 are the byte count and bit 31 is the end-of-chain flag. Bits 30:18 of the control word are ignored.
- R2: A valid descriptor copies count/4 words in ascending address order. Each word is read from source+4k and written unchanged to destination+4k, so a little-endian byte layout is preserved and no bytes are swapped.
- R3: Finishing a descriptor with bit 31 clear fetches the next descriptor at the current descriptor address plus 12. Finishing one with bit 31 set ends the chain and sets status bit 0 (read side done) and status bit 1 (write side done).
- R4: A byte count of zero, or one that is not a multiple of 256, sets status bit 4 and stops the chain. No data word of that descriptor is read or written. Data already moved for earlier descriptors stays in place.
- R5: An error response to any read stops the chain at once and sets status bit 2. This covers descriptor fetches as well as data reads. No further write is issued.
- R6: An error response to a data write stops the chain at once and sets status bit 3.
- R7: Status bits 4:0 are sticky. Writing status with bit i set clears bit i, and writing a zero leaves the bit unchanged. Status bit 8 reads 1 while the engine is running.
- R8: The irq output is high exactly while any of status bits 4:0 is set.
- R9: A start command issued while the engine is running is ignored. The running chain completes unchanged, and no descriptor is fetched from the newly written base.
- R10: The register offsets are 0 for the descriptor base (read/write), 1 for control (writing bit 0 = 1 starts) and 2 for status (read, write-one-to-clear).
- R11: mem_req holds its address, direction and write data steady until mem_ack. mem_rdata and mem_err are valid in the acknowledge cycle, and a request appears only while the engine is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access finished this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| irq | output | 1 | Interrupt, high while any status event bit is set |

## Verification
The bench builds a three-descriptor chain whose control words have the reserved bits set. A design that decodes those bits into the count copies the wrong length. A design that mis-steps the descriptor stride writes to unexpected destinations, and the write-order scoreboard catches both.

Byte counts of 0 and of 300 check that a malformed descriptor moves no data. A fault in the second descriptor of a chain checks that the first descriptor's data still lands. Error responses are injected in the middle of a read burst, in the middle of a write burst and on a descriptor fetch. These confirm that each fault stops the copy at the exact word and sets only its own status bit.

A second start issued mid-chain with a new base would, in a faulty design, restart the walk and write data out of order. The write-one-to-clear sequence exposes any status bit that clears on a zero write, and any irq that falls while another bit is still set.

// File: rtl/sgd_pkg.sv
// Package: shared constants and types for the scatter-gather copy engine.
// Assumes 32-bit words and a 2-bit register offset space.
package sgd_pkg;
    localparam logic [1:0] REG_BASE = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;

    localparam int ST_RD_DONE = 0;
    localparam int ST_WR_DONE = 1;
    localparam int ST_RD_ERR  = 2;
    localparam int ST_WR_ERR  = 3;
    localparam int ST_SG_ERR  = 4;
    localparam int ST_BUSY    = 8;
    localparam int EV_W       = 5;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_FETCH,
        WK_CHECK,
        WK_READ,
        WK_WRITE
    } walk_st_e;
endpackage

// File: rtl/sgd_desc_decode.sv
// Module: splits a descriptor control word into count and end flag and
// judges whether the count is legal (non-zero, multiple of the block size).
// Assumes BLK_BYTES is a power of two not larger than 2**CNT_W.
module sgd_desc_decode #(
    parameter int CNT_W     = 18,
    parameter int BLK_BYTES = 256
) (
    input  logic [31:0]      ctrl_word,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             end_flag,
    output logic             cnt_bad
);
    localparam int BLK_LSB = $clog2(BLK_BYTES);

    logic unused_rsvd;

    // Field extraction and legality test.
    always_comb begin
        byte_cnt = ctrl_word[CNT_W-1:0];
        end_flag = ctrl_word[31];
        cnt_bad  = (byte_cnt == '0) || (byte_cnt[BLK_LSB-1:0] != '0);
    end

    assign unused_rsvd = ^ctrl_word[30:CNT_W];
endmodule

// File: rtl/sgd_regs.sv
// Module: register file with base address, start strobe and sticky
// write-one-to-clear status; drives the interrupt level.
// Assumes event pulses last one cycle; an event wins over a same-cycle clear.
module sgd_regs #(
    parameter int AW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [1:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic [AW-1:0]            base_addr,
    output logic                     start_cmd,
    input  logic [sgd_pkg::EV_W-1:0] ev_set,
    input  logic                     busy,
    output logic [sgd_pkg::EV_W-1:0] stat_bits,
    output logic                     irq
);
    import sgd_pkg::*;

    logic [EV_W-1:0] clr_mask;

    // Decode writes into a start strobe and a clear mask.
    always_comb begin
        start_cmd = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[0];
        clr_mask  = (reg_wr && (reg_addr == REG_STAT)) ? reg_wdata[EV_W-1:0] : '0;
    end

    // Base address register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_addr <= '0;
        else if (reg_wr && (reg_addr == REG_BASE))
            base_addr <= reg_wdata[AW-1:0];
    end

    // Sticky status: set by events, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_bits <= '0;
        else
            stat_bits <= (stat_bits & ~clr_mask) | ev_set;
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_BASE: reg_rdata[AW-1:0] = base_addr;
            REG_STAT: begin
                reg_rdata[EV_W-1:0] = stat_bits;
                reg_rdata[ST_BUSY]  = busy;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |stat_bits;
endmodule

// File: rtl/sgd_walker.sv
// Module: descriptor walker and word copier. Fetches three-word descriptors,
// copies count/4 words through a holding register, follows the chain.
// Assumes one memory access outstanding; request held until acknowledge.
module sgd_walker #(
    parameter int AW        = 32,
    parameter int CNT_W     = 18,
    parameter int BLK_BYTES = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_cmd,
    input  logic [AW-1:0]            base_addr,
    output logic                     busy,
    output logic [sgd_pkg::EV_W-1:0] ev_set,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [31:0]              mem_wdata,
    input  logic                     mem_ack,
    input  logic [31:0]              mem_rdata,
    input  logic                     mem_err
);
    import sgd_pkg::*;

    localparam int WC_W      = CNT_W - 2;
    localparam int DESC_STEP = 12;

    walk_st_e         st_q;
    logic [AW-1:0]    desc_q;
    logic [1:0]       idx_q;
    logic [AW-1:0]    src_q;
    logic [AW-1:0]    dst_q;
    logic [31:0]      ctl_q;
    logic [31:0]      hold_q;
    logic [WC_W-1:0]  left_q;
    logic [CNT_W-1:0] byte_cnt;
    logic             end_flag;
    logic             cnt_bad;
    logic             unused_low;

    sgd_desc_decode #(
        .CNT_W     (CNT_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_dec (
        .ctrl_word (ctl_q),
        .byte_cnt  (byte_cnt),
        .end_flag  (end_flag),
        .cnt_bad   (cnt_bad)
    );

    assign unused_low = ^byte_cnt[1:0];

    // Memory request outputs derived from the walk state.
    always_comb begin
        mem_req   = (st_q == WK_FETCH) || (st_q == WK_READ) || (st_q == WK_WRITE);
        mem_we    = (st_q == WK_WRITE);
        mem_wdata = hold_q;
        case (st_q)
            WK_FETCH: mem_addr = desc_q + {{(AW-4){1'b0}}, idx_q, 2'b00};
            WK_READ:  mem_addr = src_q;
            WK_WRITE: mem_addr = dst_q;
            default:  mem_addr = '0;
        endcase
        busy = (st_q != WK_IDLE);
    end

    // One-cycle completion and fault events for the status register.
    always_comb begin
        ev_set = '0;
        if (mem_ack && mem_err && ((st_q == WK_FETCH) || (st_q == WK_READ)))
            ev_set[ST_RD_ERR] = 1'b1;
        if (mem_ack && mem_err && (st_q == WK_WRITE))
            ev_set[ST_WR_ERR] = 1'b1;
        if ((st_q == WK_CHECK) && cnt_bad)
            ev_set[ST_SG_ERR] = 1'b1;
        if ((st_q == WK_WRITE) && mem_ack && !mem_err && (left_q == WC_W'(1)) && end_flag) begin
            ev_set[ST_RD_DONE] = 1'b1;
            ev_set[ST_WR_DONE] = 1'b1;
        end
    end

    // Walk state machine and address/count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WK_IDLE;
            desc_q <= '0;
            idx_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            ctl_q  <= '0;
            hold_q <= '0;
            left_q <= '0;
        end else begin
            case (st_q)
                WK_IDLE: begin
                    if (start_cmd) begin
                        desc_q <= base_addr;
                        idx_q  <= '0;
                        st_q   <= WK_FETCH;
                    end
                end
                WK_FETCH: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            st_q <= WK_IDLE;
                        end else begin
                            case (idx_q)
                                2'd0:    src_q <= mem_rdata[AW-1:0];
                                2'd1:    dst_q <= mem_rdata[AW-1:0];
                                default: ctl_q <= mem_rdata;
                            endcase
                            idx_q <= idx_q + 2'd1;
                            if (idx_q == 2'd2)
                                st_q <= WK_CHECK;
                        end
                    end
                end
                WK_CHECK: begin
                    if (cnt_bad) begin
                        st_q <= WK_IDLE;
                    end else begin
                        left_q <= byte_cnt[CNT_W-1:2];
                        st_q   <= WK_READ;
                    end
                end
                WK_READ: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            st_q <= WK_IDLE;
                        end else begin
                            hold_q <= mem_rdata;
                            src_q  <= src_q + AW'(4);
                            st_q   <= WK_WRITE;
                        end
                    end
                end
                WK_WRITE: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            st_q <= WK_IDLE;
                        end else begin
                            dst_q <= dst_q + AW'(4);
                            if (left_q == WC_W'(1)) begin
                                if (end_flag) begin
                                    st_q <= WK_IDLE;
                                end else begin
                                    desc_q <= desc_q + AW'(DESC_STEP);
                                    idx_q  <= '0;
                                    st_q   <= WK_FETCH;
                                end
                            end else begin
                                left_q <= left_q - WC_W'(1);
                                st_q   <= WK_READ;
                            end
                        end
                    end
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sg_dma_engine.sv
// Module: top of the scatter-gather copy engine; joins the register file
// and the descriptor walker.
// Assumes word-aligned descriptor, source and destination addresses.
module sg_dma_engine #(
    parameter int AW        = 32,
    parameter int CNT_W     = 18,
    parameter int BLK_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err,
    output logic        irq
);
    import sgd_pkg::*;

    logic [AW-1:0]   base_addr;
    logic            start_cmd;
    logic            busy;
    logic [EV_W-1:0] ev_set;
    logic [EV_W-1:0] stat_bits;

    sgd_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .base_addr (base_addr),
        .start_cmd (start_cmd),
        .ev_set    (ev_set),
        .busy      (busy),
        .stat_bits (stat_bits),
        .irq       (irq)
    );

    sgd_walker #(
        .AW        (AW),
        .CNT_W     (CNT_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cmd (start_cmd),
        .base_addr (base_addr),
        .busy      (busy),
        .ev_set    (ev_set),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_err   (mem_err)
    );
endmodule

// File: rtl/sgd_checker.sv
// Module: protocol and status checks for the copy engine, bound to the top.
// Assumes the bound signals are the top's own ports and internal nets.
module sgd_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic [4:0]    stat_bits,
    input logic          busy,
    input logic          irq
);
    // A pending request keeps its attributes until acknowledged.
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

    // Requests only while the engine runs.
    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R11

    // The interrupt only rises at the end of a run.
    AST_IRQ_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(busy)); // R8

    // A start during a pending access does not move the access.
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && (reg_addr == 2'd1) && reg_wdata[0] && mem_req && !mem_ack) |=> $stable(mem_addr)); // R9

    // A set status bit survives anything but a write of one to it.
    for (genvar gi = 0; gi < 5; gi++) begin : g_sticky
        AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_bits[gi] && !(reg_wr && (reg_addr == 2'd2) && reg_wdata[gi])) |=> stat_bits[gi]); // R7
    end
endmodule

bind sg_dma_engine sgd_checker #(.AW(AW)) u_sgd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .stat_bits (stat_bits),
    .busy      (busy),
    .irq       (irq)
);

// File: tb/sg_dma_engine_bench.sv
// Bench: memory model with error injection, write-order scoreboard,
// register-level driver tasks.
module sg_dma_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        irq;

    logic [31:0] mem [0:MEM_WORDS-1];
    logic [63:0] exp_q [$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          lat = 0;
    int          wcnt = 0;
    int          wr_total = 0;
    int          cycles = 0;
    logic [31:0] err_lo = 32'hFFFF_FFF0;
    logic [31:0] err_hi = 32'hFFFF_FFF0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sg_dma_engine u_sg_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model and scoreboard monitor, on the falling edge.
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            mem_ack = 1'b0; mem_err = 1'b0; wcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0; mem_err = 1'b0;
        end else if (mem_req) begin
            if (wcnt < lat) wcnt++;
            else begin
                logic e;
                wcnt = 0;
                e = (mem_addr >= err_lo) && (mem_addr < err_hi);
                mem_ack = 1'b1;
                mem_err = e;
                if (mem_we) begin
                    if (!e) begin
                        mem[mem_addr[13:2]] = mem_wdata;
                        wr_total++;
                        if (exp_q.size() == 0) begin
                            n_cmp++; n_bad++;
                            $display("FAIL R2 unexpected write actual=%h@%h expected=none", mem_wdata, mem_addr);
                        end else begin
                            logic [63:0] x;
                            x = exp_q.pop_front();
                            check("R2 write", mem_addr, x[63:32]);
                            check("R2 data", mem_wdata, x[31:0]);
                        end
                    end
                end else begin
                    mem_rdata = e ? 32'h0 : mem[mem_addr[13:2]];
                end
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input int at, input logic [31:0] s, input logic [31:0] d, input logic [31:0] ctl);
        mem[at >> 2]       = s;
        mem[(at >> 2) + 1] = d;
        mem[(at >> 2) + 2] = ctl;
    endtask

    // Driver: queue the writes a descriptor should produce.
    task automatic push_expect(input logic [31:0] s, input logic [31:0] d, input int nwords);
        for (int k = 0; k < nwords; k++)
            exp_q.push_back({d + 32'(4*k), mem[(s >> 2) + k]});
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        int guard;
        guard = 0;
        reg_read(2'd2, st);
        while (st[8] && guard < 40000) begin
            reg_read(2'd2, st);
            guard++;
        end
        if (st[8]) begin
            n_cmp++; n_bad++;
            $display("FAIL R3 engine stuck busy actual=1 expected=0");
        end
    endtask

    task automatic run(input logic [31:0] base);
        reg_write(2'd0, base);
        reg_write(2'd1, 32'h1);
        wait_idle();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] st;
        int w0;
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = {i[15:0], ~i[15:0]} ^ 32'h5A00_00A5;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        reg_read(2'd2, st); check("R7 reset status", st, 32'h0);
        check("R8 reset irq", {31'd0, irq}, 32'd0);
        check("R11 reset req", {31'd0, mem_req}, 32'd0);
        reg_read(2'd0, st); check("R10 reset base", st, 32'h0);

        // Single descriptor, zero latency
        lat = 0;
        put_desc(32'h000, 32'h1000, 32'h2000, 32'h8000_0100);
        push_expect(32'h1000, 32'h2000, 64);
        run(32'h000);
        reg_read(2'd2, st); check("R3 single done", st, 32'h3);
        check("R8 irq on done", {31'd0, irq}, 32'd1);
        check("R2 queue drained", exp_q.size(), 0);

        // Write-one-to-clear
        reg_write(2'd2, 32'h1);
        reg_read(2'd2, st); check("R7 clear bit0 only", st, 32'h2);
        check("R8 irq while bit1", {31'd0, irq}, 32'd1);
        reg_write(2'd2, 32'h0);
        reg_read(2'd2, st); check("R7 zero write keeps", st, 32'h2);
        reg_write(2'd2, 32'h2);
        reg_read(2'd2, st); check("R7 all cleared", st, 32'h0);
        check("R8 irq low", {31'd0, irq}, 32'd0);
        reg_write(2'd0, 32'h40);
        reg_read(2'd0, st); check("R10 base readback", st, 32'h40);

        // Three-descriptor chain, reserved bits set, start retried while busy
        lat = 2;
        put_desc(32'h100, 32'h1400, 32'h2400, 32'h7FFC_0200);
        put_desc(32'h10C, 32'h1000, 32'h2800, 32'h0000_0100);
        put_desc(32'h118, 32'h1800, 32'h2C00, 32'h8000_0100);
        push_expect(32'h1400, 32'h2400, 128);
        push_expect(32'h1000, 32'h2800, 64);
        push_expect(32'h1800, 32'h2C00, 64);
        reg_write(2'd0, 32'h100);
        reg_write(2'd1, 32'h1);
        repeat (30) @(negedge clk);
        reg_read(2'd2, st); check("R7 busy bit", {31'd0, st[8]}, 32'd1);
        reg_write(2'd0, 32'h000);
        reg_write(2'd1, 32'h1);          // R9: must be ignored
        wait_idle();
        reg_read(2'd2, st); check("R3 chain done", st, 32'h3);
        check("R1 chain queue drained", exp_q.size(), 0);
        w0 = wr_total;
        repeat (40) @(negedge clk);
        check("R9 no restart", wr_total, w0);
        reg_read(2'd0, st); check("R10 base new value", st, 32'h0);
        reg_write(2'd2, 32'h1F);

        // Bad counts
        put_desc(32'h180, 32'h1000, 32'h3000, 32'h8000_012C);
        w0 = wr_total;
        run(32'h180);
        reg_read(2'd2, st); check("R4 count 300", st, 32'h10);
        check("R4 no writes 300", wr_total, w0);
        check("R8 irq on sg error", {31'd0, irq}, 32'd1);
        reg_write(2'd2, 32'h1F);
        put_desc(32'h180, 32'h1000, 32'h3000, 32'h8000_0000);
        run(32'h180);
        reg_read(2'd2, st); check("R4 count zero", st, 32'h10);
        check("R4 no writes zero", wr_total, w0);
        reg_write(2'd2, 32'h1F);
        put_desc(32'h200, 32'h1000, 32'h3000, 32'h0000_0100);
        put_desc(32'h20C, 32'h1100, 32'h3400, 32'h8000_0180);
        push_expect(32'h1000, 32'h3000, 64);
        run(32'h200);
        reg_read(2'd2, st); check("R4 second desc bad", st, 32'h10);
        check("R4 first desc data", exp_q.size(), 0);
        reg_write(2'd2, 32'h1F);

        // Read error mid burst
        lat = 1;
        err_lo = 32'h1020; err_hi = 32'h1024;
        put_desc(32'h300, 32'h1000, 32'h3400, 32'h8000_0100);
        push_expect(32'h1000, 32'h3400, 8);
        run(32'h300);
        reg_read(2'd2, st); check("R5 read error", st, 32'h4);
        check("R5 stops at word", exp_q.size(), 0);
        reg_write(2'd2, 32'h1F);

        // Write error mid burst
        err_lo = 32'h3810; err_hi = 32'h3814;
        put_desc(32'h300, 32'h1000, 32'h3800, 32'h8000_0100);
        push_expect(32'h1000, 32'h3800, 4);
        w0 = wr_total;
        run(32'h300);
        reg_read(2'd2, st); check("R6 write error", st, 32'h8);
        check("R6 writes before error", wr_total, w0 + 4);
        reg_write(2'd2, 32'h1F);

        // Descriptor fetch error
        err_lo = 32'h3F00; err_hi = 32'h3F04;
        w0 = wr_total;
        run(32'h3F00);
        reg_read(2'd2, st); check("R5 fetch error", st, 32'h4);
        check("R5 no writes", wr_total, w0);

        finish_run();
    end
endmodule